// File: doc/BRIEF.md
# Tiled Memory Composer

This block presents one logical single-port synchronous memory and builds it out of a grid of small, fixed-size behavioural memory tiles. Tiles placed next to each other widen the stored word. Rows of tiles, called banks, extend the address range. The bank that answered the last read drives the output through a combinational multiplexer.

Some tile types have no per-byte write mask. In that case the block cuts the word into tiles exactly one mask granule wide and gives each of them its own write strobe. The chip-enable, write-enable, read-enable and mask pins of each tile can each be active high or active low, and the wrapper drives the correct level for each one.

A logical size smaller than one tile is rounded up to whole tiles. The spare bits and rows are never written and are never visible at the port. The block is meant to sit behind a cache or buffer controller that needs a memory of a size not offered directly in the tile library.

Top module: `csram_array`

## Requirements
- R1: Read data for an address appears on `rdData` in the cycle after `rdEn` is sampled high. It reflects every write accepted at an earlier edge.
- R2: Write mask bit i enables data bits `[i*MASK_GRAN +: MASK_GRAN]` (with 8, bit i covers byte i). Granules whose mask bit is 0 keep their stored value.
- R3: Address a maps to bank a / TILE_D and row a mod TILE_D. Writes to one bank never alter data held in another bank.
- R4: While `rdEn` is low, `rdData` keeps its last value, including across writes to the address last read.
- R5: After reset `rdData` is zero until the first read completes.
- R6: A read and a write to the same address in the same cycle return the contents from before the write. The write still takes effect.
- R7: In any cycle at most one bank of tiles sees an active chip enable. No bank is enabled when both `wrEn` and `rdEn` are low.
- R8: A tile's write strobe is active only when `wrEn` is high and its bank is addressed. In narrow-tile mode, its granule's mask bit must also be set.
- R9: Masked-tile and narrow-tile builds behave identically at the logical port, for either level of every tile control pin.
- R10: A logical width or depth smaller than one tile is served by padding out to a whole tile. The padding never shows at the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the tiles and the control registers |
| rst | input | 1 | Synchronous active-high reset of the read-select state |
| addr | input | clog2(LOG_D) | Word address for reads and writes |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| wrData | input | LOG_W | Write data |
| wrMask | input | LOG_W/MASK_GRAN | Per-granule write enable |
| rdData | output | LOG_W | Read data, valid the cycle after a read |

## Verification
The checks assume that the address stays below the logical depth whenever either enable is high. With a non-power-of-two depth the address bus can encode rows that do not exist, and a dedicated property flags any such request. The stimulus reduces every address modulo each instance's own depth, so only legal rows are used. The bench puts the same operations into three builds side by side:
- masked tiles with active-high pins;
- byte-wide tiles with every pin active low;
- an over-provisioned 24-bit by 24-word memory on a 32 by 32 tile.

Read-while-write and mask patterns are applied through the same path in all three builds.

// File: rtl/csram_pkg.sv
package csram_pkg;
  localparam int MAX_BANK_W = 8;

  typedef struct packed {
    logic                  wrStb;
    logic                  rdStb;
    logic [MAX_BANK_W-1:0] bankSel;
    logic [MAX_BANK_W-1:0] rdBank;
    logic                  rdSeen;
  } arrStrobe_t;

  function automatic int ceilDiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/csram_tile.sv
module csram_tile #(
  parameter int W        = 16,
  parameter int D        = 32,
  parameter bit HAS_MASK = 1'b1,
  parameter int GRAN     = 8,
  parameter bit CE_LOW   = 1'b0,
  parameter bit WE_LOW   = 1'b0,
  parameter bit RE_LOW   = 1'b0,
  parameter bit MASK_LOW = 1'b0,
  localparam int AW      = (D > 1) ? $clog2(D) : 1,
  localparam int MB      = HAS_MASK ? (W / GRAN) : 1
) (
  input  logic          clk,
  input  logic          cePin,
  input  logic          wePin,
  input  logic          rePin,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  input  logic [MB-1:0] maskPin,
  output logic [W-1:0]  dout
);
  logic [W-1:0]  mem [D];
  logic          ceOn, weOn, reOn;
  logic [MB-1:0] maskOn;
  logic [W-1:0]  bitEn;

  assign ceOn   = cePin ^ CE_LOW;
  assign weOn   = wePin ^ WE_LOW;
  assign reOn   = rePin ^ RE_LOW;
  assign maskOn = maskPin ^ {MB{MASK_LOW}};

  always_comb begin
    for (int i = 0; i < W; i++) begin
      bitEn[i] = HAS_MASK ? maskOn[(i / GRAN) % MB] : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ceOn) begin
      if (reOn) dout <= mem[addr];
      if (weOn) mem[addr] <= (mem[addr] & ~bitEn) | (din & bitEn);
    end
  end
endmodule

// File: rtl/csram_ctrl.sv
module csram_ctrl
  import csram_pkg::*;
#(
  parameter int LOG_D   = 64,
  parameter int TILE_AW = 5,
  localparam int ADDR_W = (LOG_D > 1) ? $clog2(LOG_D) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic               rdEn,
  output arrStrobe_t         strobe,
  output logic [TILE_AW-1:0] tileAddr
);
  logic [MAX_BANK_W-1:0] curBank;
  logic [MAX_BANK_W-1:0] rdBankQ;
  logic                  rdSeenQ;

  assign curBank  = MAX_BANK_W'(addr >> TILE_AW);
  assign tileAddr = TILE_AW'(addr);

  always_comb begin
    strobe.wrStb   = wrEn;
    strobe.rdStb   = rdEn;
    strobe.bankSel = curBank;
    strobe.rdBank  = rdBankQ;
    strobe.rdSeen  = rdSeenQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdBankQ <= '0;
      rdSeenQ <= 1'b0;
    end else if (rdEn) begin
      rdBankQ <= curBank;
      rdSeenQ <= 1'b1;
    end
  end

  // R4
  rdbank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdBankQ));

  // R5
  rdseen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rdSeenQ |=> rdSeenQ);

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn || rdEn) |-> (int'(addr) < LOG_D));
endmodule

// File: rtl/csram_datapath.sv
module csram_datapath
  import csram_pkg::*;
#(
  parameter int LOG_W        = 32,
  parameter int LOG_D        = 64,
  parameter int TILE_W       = 16,
  parameter int TILE_D       = 32,
  parameter int MASK_GRAN    = 8,
  parameter bit TILE_HAS_MASK = 1'b1,
  parameter bit CE_ACT_LOW   = 1'b0,
  parameter bit WE_ACT_LOW   = 1'b0,
  parameter bit RE_ACT_LOW   = 1'b0,
  parameter bit MASK_ACT_LOW = 1'b0,
  localparam int TILE_AW     = (TILE_D > 1) ? $clog2(TILE_D) : 1,
  localparam int MASK_N      = LOG_W / MASK_GRAN
) (
  input  logic               clk,
  input  logic               rst,
  input  arrStrobe_t         strobe,
  input  logic [TILE_AW-1:0] tileAddr,
  input  logic [LOG_W-1:0]   wrData,
  input  logic [MASK_N-1:0]  wrMask,
  output logic [LOG_W-1:0]   rdData
);
  localparam int COL_W     = TILE_HAS_MASK ? TILE_W : MASK_GRAN;
  localparam int NUM_COLS  = ceilDiv(LOG_W, COL_W);
  localparam int NUM_BANKS = ceilDiv(LOG_D, TILE_D);
  localparam int PAD_W     = NUM_COLS * COL_W;
  localparam int PAD_M     = PAD_W / MASK_GRAN;
  localparam int COL_M     = TILE_HAS_MASK ? (COL_W / MASK_GRAN) : 1;

  logic [PAD_W-1:0] padData;
  logic [PAD_M-1:0] padMask;
  logic [NUM_BANKS-1:0][PAD_W-1:0] bankDout;
  logic [NUM_BANKS-1:0][NUM_COLS-1:0] cePin, wePin, rePin;
  logic [NUM_BANKS-1:0][NUM_COLS-1:0][COL_M-1:0] maskPin;
  logic [NUM_BANKS-1:0] ceSeen;
  logic [NUM_BANKS*NUM_COLS-1:0] weSeen;

  assign padData = PAD_W'(wrData);
  assign padMask = PAD_M'(wrMask);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bankHit;
    assign bankHit   = (strobe.bankSel == MAX_BANK_W'(b));
    assign ceSeen[b] = cePin[b][0] ^ CE_ACT_LOW;

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      logic weAct;
      if (TILE_HAS_MASK) begin : g_masked
        assign weAct      = bankHit & strobe.wrStb;
        assign maskPin[b][c] = padMask[c*COL_M +: COL_M] ^ {COL_M{MASK_ACT_LOW}};
      end else begin : g_split
        assign weAct      = bankHit & strobe.wrStb & padMask[c];
        assign maskPin[b][c] = {COL_M{MASK_ACT_LOW}};
      end
      assign cePin[b][c] = (bankHit & (strobe.wrStb | strobe.rdStb)) ^ CE_ACT_LOW;
      assign wePin[b][c] = weAct ^ WE_ACT_LOW;
      assign rePin[b][c] = (bankHit & strobe.rdStb) ^ RE_ACT_LOW;
      assign weSeen[b*NUM_COLS + c] = wePin[b][c] ^ WE_ACT_LOW;

      csram_tile #(
        .W(COL_W), .D(TILE_D), .HAS_MASK(TILE_HAS_MASK), .GRAN(MASK_GRAN),
        .CE_LOW(CE_ACT_LOW), .WE_LOW(WE_ACT_LOW), .RE_LOW(RE_ACT_LOW),
        .MASK_LOW(MASK_ACT_LOW)
      ) u_tile (
        .clk    (clk),
        .cePin  (cePin[b][c]),
        .wePin  (wePin[b][c]),
        .rePin  (rePin[b][c]),
        .addr   (tileAddr),
        .din    (padData[c*COL_W +: COL_W]),
        .maskPin(maskPin[b][c]),
        .dout   (bankDout[b][c*COL_W +: COL_W])
      );

      if (!TILE_HAS_MASK) begin : g_split_chk
        // R8
        split_we_mask_chk: assert property (@(posedge clk) disable iff (rst)
          weSeen[b*NUM_COLS + c] |-> padMask[c]);
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdSeen) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strobe.rdBank == MAX_BANK_W'(b)) rdData = LOG_W'(bankDout[b]);
      end
    end
  end

  // R7
  bank_ce_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ceSeen));

  // R7
  bank_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.wrStb && !strobe.rdStb) |-> (ceSeen == '0));

  // R8
  we_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrStb |-> (weSeen == '0));
endmodule

// File: rtl/csram_array.sv
module csram_array
  import csram_pkg::*;
#(
  parameter int LOG_W         = 32,
  parameter int LOG_D         = 64,
  parameter int TILE_W        = 16,
  parameter int TILE_D        = 32,
  parameter int MASK_GRAN     = 8,
  parameter bit TILE_HAS_MASK = 1'b1,
  parameter bit CE_ACT_LOW    = 1'b0,
  parameter bit WE_ACT_LOW    = 1'b0,
  parameter bit RE_ACT_LOW    = 1'b0,
  parameter bit MASK_ACT_LOW  = 1'b0,
  localparam int ADDR_W       = (LOG_D > 1) ? $clog2(LOG_D) : 1,
  localparam int TILE_AW      = (TILE_D > 1) ? $clog2(TILE_D) : 1,
  localparam int MASK_N       = LOG_W / MASK_GRAN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [LOG_W-1:0]  wrData,
  input  logic [MASK_N-1:0] wrMask,
  output logic [LOG_W-1:0]  rdData
);
  arrStrobe_t         strobe;
  logic [TILE_AW-1:0] tileAddr;

  csram_ctrl #(.LOG_D(LOG_D), .TILE_AW(TILE_AW)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .strobe(strobe), .tileAddr(tileAddr)
  );

  csram_datapath #(
    .LOG_W(LOG_W), .LOG_D(LOG_D), .TILE_W(TILE_W), .TILE_D(TILE_D),
    .MASK_GRAN(MASK_GRAN), .TILE_HAS_MASK(TILE_HAS_MASK),
    .CE_ACT_LOW(CE_ACT_LOW), .WE_ACT_LOW(WE_ACT_LOW),
    .RE_ACT_LOW(RE_ACT_LOW), .MASK_ACT_LOW(MASK_ACT_LOW)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .tileAddr(tileAddr),
    .wrData(wrData), .wrMask(wrMask), .rdData(rdData)
  );

  // R4
  rddata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));
endmodule

// File: tb/sim_csram_array.sv
`timescale 1ns/1ps
module sim_csram_array;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  addr = '0;
  logic [4:0]  addr2 = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrMask = '0;
  logic [31:0] rd0, rd1;
  logic [23:0] rd2;

  int checkCnt = 0, failCnt = 0;
  bit finished = 1'b0;
  logic [31:0] refA [64];
  logic [23:0] refB [24];

  always #5 clk = ~clk;

  csram_array u0 (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .wrMask(wrMask), .rdData(rd0));

  csram_array #(.TILE_HAS_MASK(1'b0), .CE_ACT_LOW(1'b1), .WE_ACT_LOW(1'b1),
    .RE_ACT_LOW(1'b1), .MASK_ACT_LOW(1'b1)) u1 (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .wrMask(wrMask), .rdData(rd1));

  csram_array #(.LOG_W(24), .LOG_D(24), .TILE_W(32), .TILE_D(32),
    .CE_ACT_LOW(1'b1), .MASK_ACT_LOW(1'b1)) u2 (
    .clk(clk), .rst(rst), .addr(addr2), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData[23:0]), .wrMask(wrMask[2:0]), .rdData(rd2));

  // {wr, rd, addr[5:0], data[31:0], mask[3:0]}
  localparam logic [43:0] VEC [10] = '{
    {1'b1, 1'b0, 6'd3,  32'hA5A5_0001, 4'hF},
    {1'b0, 1'b1, 6'd3,  32'h0,         4'h0},
    {1'b1, 1'b0, 6'd35, 32'h1234_5678, 4'hF},
    {1'b0, 1'b1, 6'd3,  32'h0,         4'h0},
    {1'b0, 1'b1, 6'd35, 32'h0,         4'h0},
    {1'b1, 1'b0, 6'd3,  32'hFFFF_FFFF, 4'b0101},
    {1'b0, 1'b1, 6'd3,  32'h0,         4'h0},
    {1'b1, 1'b1, 6'd35, 32'h0,         4'hF},
    {1'b0, 1'b1, 6'd35, 32'h0,         4'h0},
    {1'b1, 1'b0, 6'd63, 32'hDEAD_BEEF, 4'b1000}
  };

  function automatic logic [31:0] merge(input logic [31:0] old,
                                        input logic [31:0] d,
                                        input logic [3:0] m);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string tag, input string who,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
    end
  endtask

  task automatic doOp(input logic wr, input logic rd, input logic [5:0] a,
                      input logic [31:0] d, input logic [3:0] m, input string tag);
    logic [31:0] e01;
    logic [23:0] e2;
    int a2;
    a2  = int'(a) % 24;
    e01 = refA[a];
    e2  = refB[a2];
    addr = a; addr2 = 5'(a2); wrData = d; wrMask = m; wrEn = wr; rdEn = rd;
    @(posedge clk);
    if (wr) begin
      refA[a]  = merge(refA[a], d, m);
      refB[a2] = 24'(merge({8'h0, refB[a2]}, {8'h0, d[23:0]}, {1'b0, m[2:0]}));
    end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    if (rd) begin
      chk(tag, "u0", rd0, e01);
      chk(tag, "u1", rd1, e01);
      chk(tag, "u2", {8'h0, rd2}, {8'h0, e2});
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) refA[i] = '0;
    for (int i = 0; i < 24; i++) refB[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R5: zero after reset, and still zero after a write with no read
    chk("R5", "u0", rd0, 32'h0);
    chk("R5", "u1", rd1, 32'h0);
    chk("R5", "u2", {8'h0, rd2}, 32'h0);
    doOp(1'b1, 1'b0, 6'd10, 32'h0BAD_CAFE, 4'hF, "R5");
    chk("R5", "u0", rd0, 32'h0);
    chk("R5", "u2", {8'h0, rd2}, 32'h0);

    // fill every row with known data (R1, R10)
    for (int i = 0; i < 64; i++)
      doOp(1'b1, 1'b0, 6'(i), 32'h5A00_0000 + 32'(i * 32'h0101_0101), 4'hF, "R1");

    // table: R1 R2 R3 R6 (entry 7 is a same-cycle read and write)
    for (int i = 0; i < 10; i++)
      doOp(VEC[i][43], VEC[i][42], VEC[i][41:36], VEC[i][35:4], VEC[i][3:0],
           "R1 R2 R3 R6");

    // R4: output holds across idle cycles and a write to the same row
    doOp(1'b0, 1'b1, 6'd20, 32'h0, 4'h0, "R4");
    begin
      logic [31:0] held0, held1;
      logic [23:0] held2;
      held0 = rd0; held1 = rd1; held2 = rd2;
      doOp(1'b1, 1'b0, 6'd20, 32'hFFFF_FFFF, 4'hF, "R4");
      @(negedge clk);
      chk("R4", "u0", rd0, held0);
      chk("R4", "u1", rd1, held1);
      chk("R4", "u2", {8'h0, rd2}, {8'h0, held2});
    end
    doOp(1'b0, 1'b1, 6'd20, 32'h0, 4'h0, "R4");

    // random traffic: R1 R2 R3 R6 R7 R8 R9 R10
    for (int i = 0; i < 600; i++)
      doOp(1'($urandom), 1'($urandom), 6'($urandom), $urandom, 4'($urandom),
           "R1 R2 R3 R6 R7 R8 R9 R10");

    // read back every row at the end (R3 R9 R10)
    for (int i = 0; i < 64; i++)
      doOp(1'b0, 1'b1, 6'(i), 32'h0, 4'h0, "R3 R9 R10");

    summary();
  end
endmodule